// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and a Gregorian date: seconds, minutes, hours, day of week, day of month, month and a three-digit year. An internal prescaler counts pulses of a 32768 Hz reference (`ref_tick`, one clock-wide pulse per reference period) and produces a one-second strobe. That strobe advances the calendar while the global enable is set, and it is also brought out so that alarm logic can compare on the same second.

Software sees each field as packed BCD on the output ports. It sets the time by writing a BCD value to one field at a time, chosen by a field select. These writes take effect only while the global enable is set. Internally the fields are binary. The year is held as an offset from 1900 in the range 0 to 999, so the leap-year rule, including the century exceptions, is applied to the offset year plus 1900.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x00, day of month 0x01, month 0x01 and year 0x000, and `sec_strobe` is low.
- R2: While enabled, `sec_strobe` is high for exactly one clock after every REF_DIV enabled reference pulses. A 0-to-1 change of `enable` restarts the count, so the first strobe is visible in the fifth clock after `enable` rises when REF_DIV is 4 and `ref_tick` is held high. No strobe appears while `enable` is low.
- R3: Each strobe advances the seconds. Seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0 with a carry into the date.
- R4: The day-of-week and day-of-month fields both advance on the hour wrap. Day of week counts 0 to 6 and returns to 0.
- R5: Months 4, 6, 9 and 11 have 30 days, February has 28 or 29, and all other months have 31. Past the last day, the day returns to 1 and the month advances.
- R6: February has 29 days when (year+1900) is divisible by 4 and not by 100, or is divisible by 400. For example, year 0x124 and year 0x100 are leap years, while year 0x000 and year 0x200 are not.
- R7: After December 31 the month returns to 1 and the year increments. Year 999 wraps to 000.
- R8: The field select `wr_sel` is 0=seconds, 1=minutes, 2=hours, 3=day of week, 4=day of month, 5=month (1 to 12), 6=year. A value is given as packed BCD in `wr_data`: two digits in [7:0], and for the year a hundreds digit in [11:8]. It reads back in the same encoding on the matching output.
- R9: While `enable` is low, writes are ignored and the time holds.
- R10: When a write and a one-second advance fall in the same clock, the write is applied and the whole advance for that second, including its carries, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock pulse per 32768 Hz reference period |
| enable | input | 1 | Global enable for counting and time writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select (encoding in R8) |
| wr_data | input | 12 | BCD write value |
| sec_strobe | output | 1 | One-second strobe |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 8 | Day of week, BCD 0 to 6 |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month, BCD 1 to 12 |
| year_bcd | output | 12 | Year offset, three BCD digits |

## Verification
A software write to a time field can land in the same clock as the one-second advance. The bench provokes this by waiting until the strobe is observed high and, in that same cycle, writing the seconds while the clock stands at 10:59:59. The write is judged to have won only if the seconds hold the written value and the minute and hour carries that the advance would have caused are both absent.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [9:0] year;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam logic [2:0] SEL_SEC  = 3'd0;
  localparam logic [2:0] SEL_MIN  = 3'd1;
  localparam logic [2:0] SEL_HOUR = 3'd2;
  localparam logic [2:0] SEL_WDAY = 3'd3;
  localparam logic [2:0] SEL_MDAY = 3'd4;
  localparam logic [2:0] SEL_MON  = 3'd5;
  localparam logic [2:0] SEL_YEAR = 3'd6;

  function automatic logic [7:0] bin_to_bcd2(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v - t * 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [11:0] bin_to_bcd3(input logic [9:0] v);
    logic [9:0] h;
    logic [9:0] r;
    h = v / 10'd100;
    r = v - h * 10'd100;
    return {h[3:0], bin_to_bcd2(r[6:0])};
  endfunction

  function automatic logic [6:0] bcd2_to_bin(input logic [7:0] b);
    return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
  endfunction

  function automatic logic [9:0] bcd3_to_bin(input logic [11:0] b);
    return {6'b0, b[11:8]} * 10'd100 + {3'b000, bcd2_to_bin(b[7:0])};
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int REF_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ref_tick,
  output logic sec_pulse
);
  localparam int CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q;
  logic             pulse_d;
  logic             restart;

  always_comb begin
    restart = enable & ~en_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (enable && ref_tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      en_q      <= 1'b0;
      sec_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      en_q      <= enable;
      sec_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/cal_month_length.sv
module cal_month_length #(
  parameter int YEAR_BASE = 1900
) (
  input  logic [3:0] mon,
  input  logic [9:0] year,
  output logic [4:0] days
);
  logic [11:0] full_year;
  logic        leap;

  always_comb begin
    full_year = {2'b00, year} + 12'(YEAR_BASE);
    leap = ((full_year % 12'd4 == 12'd0) && (full_year % 12'd100 != 12'd0)) ||
           (full_year % 12'd400 == 12'd0);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: days = 5'd30;
      4'd2:                    days = leap ? 5'd29 : 5'd28;
      default:                 days = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sec_pulse,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [11:0] wr_data,
  input  logic [4:0] days_in_month,
  output cal_time_t  tm
);
  cal_time_t tm_d;
  cal_time_t roll;
  logic      do_write;
  logic      do_adv;
  logic [6:0] wbin;
  logic [9:0] ybin;

  always_comb begin
    roll = tm;
    if (tm.sec >= 6'd59) begin
      roll.sec = '0;
      if (tm.min >= 6'd59) begin
        roll.min = '0;
        if (tm.hour >= 5'd23) begin
          roll.hour = '0;
          roll.wday = (tm.wday >= 3'd6) ? 3'd0 : tm.wday + 3'd1;
          if (tm.mday >= days_in_month) begin
            roll.mday = 5'd1;
            if (tm.mon >= 4'd12) begin
              roll.mon  = 4'd1;
              roll.year = (tm.year >= 10'd999) ? 10'd0 : tm.year + 10'd1;
            end else begin
              roll.mon = tm.mon + 4'd1;
            end
          end else begin
            roll.mday = tm.mday + 5'd1;
          end
        end else begin
          roll.hour = tm.hour + 5'd1;
        end
      end else begin
        roll.min = tm.min + 6'd1;
      end
    end else begin
      roll.sec = tm.sec + 6'd1;
    end
  end

  always_comb begin
    do_write = wr_en & enable;
    do_adv   = sec_pulse & enable;
    wbin     = bcd2_to_bin(wr_data[7:0]);
    ybin     = bcd3_to_bin(wr_data);
    tm_d     = tm;
    if (do_write) begin
      case (wr_sel)
        SEL_SEC:  tm_d.sec  = wbin[5:0];
        SEL_MIN:  tm_d.min  = wbin[5:0];
        SEL_HOUR: tm_d.hour = wbin[4:0];
        SEL_WDAY: tm_d.wday = wbin[2:0];
        SEL_MDAY: tm_d.mday = wbin[4:0];
        SEL_MON:  tm_d.mon  = wbin[3:0];
        SEL_YEAR: tm_d.year = ybin;
        default:  tm_d = tm;
      endcase
    end else if (do_adv) begin
      tm_d = roll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm.year <= '0;
      tm.mon  <= 4'd1;
      tm.mday <= 5'd1;
      tm.wday <= '0;
      tm.hour <= '0;
      tm.min  <= '0;
      tm.sec  <= '0;
    end else if (do_write || do_adv) begin
      tm <= tm_d;
    end
  end
endmodule

// File: rtl/cal_bcd_view.sv
module cal_bcd_view
  import cal_pkg::*;
(
  input  cal_time_t   tm,
  output logic [7:0]  sec_bcd,
  output logic [7:0]  min_bcd,
  output logic [7:0]  hour_bcd,
  output logic [7:0]  wday_bcd,
  output logic [7:0]  mday_bcd,
  output logic [7:0]  mon_bcd,
  output logic [11:0] year_bcd
);
  always_comb begin
    sec_bcd  = bin_to_bcd2({1'b0, tm.sec});
    min_bcd  = bin_to_bcd2({1'b0, tm.min});
    hour_bcd = bin_to_bcd2({2'b00, tm.hour});
    wday_bcd = bin_to_bcd2({4'b0000, tm.wday});
    mday_bcd = bin_to_bcd2({2'b00, tm.mday});
    mon_bcd  = bin_to_bcd2({3'b000, tm.mon});
    year_bcd = bin_to_bcd3(tm.year);
  end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
  import cal_pkg::*;
#(
  parameter int REF_DIV   = 32768,
  parameter int YEAR_BASE = 1900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        enable,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [11:0] wr_data,
  output logic        sec_strobe,
  output logic [7:0]  sec_bcd,
  output logic [7:0]  min_bcd,
  output logic [7:0]  hour_bcd,
  output logic [7:0]  wday_bcd,
  output logic [7:0]  mday_bcd,
  output logic [7:0]  mon_bcd,
  output logic [11:0] year_bcd
);
  logic      rst_meta_q, rst_sync_n;
  cal_time_t tm;
  logic [4:0] days_in_month;

  // reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cal_prescaler #(.REF_DIV(REF_DIV)) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .ref_tick  (ref_tick),
    .sec_pulse (sec_strobe)
  );

  cal_month_length #(.YEAR_BASE(YEAR_BASE)) u_month_len (
    .mon  (tm.mon),
    .year (tm.year),
    .days (days_in_month)
  );

  cal_time_core u_core (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .enable        (enable),
    .sec_pulse     (sec_strobe),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .days_in_month (days_in_month),
    .tm            (tm)
  );

  cal_bcd_view u_view (
    .tm       (tm),
    .sec_bcd  (sec_bcd),
    .min_bcd  (min_bcd),
    .hour_bcd (hour_bcd),
    .wday_bcd (wday_bcd),
    .mday_bcd (mday_bcd),
    .mon_bcd  (mon_bcd),
    .year_bcd (year_bcd)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [11:0] wr_data,
  input logic        sec_strobe,
  input logic [7:0]  sec_bcd,
  input logic [7:0]  min_bcd,
  input logic [7:0]  hour_bcd,
  input logic [7:0]  wday_bcd,
  input logic [7:0]  mday_bcd,
  input logic [7:0]  mon_bcd,
  input logic [11:0] year_bcd
);
  logic lo_ok, hi_ok;
  assign lo_ok = (wr_data[3:0] <= 4'd9) && (wr_data[7:4] <= 4'd5);
  assign hi_ok = lo_ok && (wr_data[11:8] <= 4'd9);

  // R2: a strobe only follows a cycle with the enable set
  a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> $past(enable));

  // R3: time digits stay legal
  a_r3_time_digits_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_bcd[7:4] <= 4'd5) && (sec_bcd[3:0] <= 4'd9) &&
    (min_bcd[7:4] <= 4'd5) && (min_bcd[3:0] <= 4'd9) && (hour_bcd <= 8'h23));

  // R4: day of week within 0..6
  a_r4_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
    wday_bcd <= 8'h06);

  // R5: day of month within 1..31
  a_r5_mday_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mday_bcd != 8'h00) && (mday_bcd <= 8'h31));

  // R8: month within 1..12
  a_r8_month_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_bcd != 8'h00) && (mon_bcd <= 8'h12));

  // R8: a legal year write reads back
  a_r8_year_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && wr_sel == 3'd6 && hi_ok) |=> (year_bcd == $past(wr_data)));

  // R9: nothing moves while disabled
  a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(sec_bcd) && $stable(min_bcd) && $stable(hour_bcd) &&
                 $stable(wday_bcd) && $stable(mday_bcd) && $stable(mon_bcd) &&
                 $stable(year_bcd)));

  // R10: a legal seconds write wins over any advance
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && wr_sel == 3'd0 && lo_ok) |=> (sec_bcd == $past(wr_data[7:0])));
endmodule

bind bcd_calendar_counter cal_checker u_cal_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .sec_strobe (sec_strobe),
  .sec_bcd    (sec_bcd),
  .min_bcd    (min_bcd),
  .hour_bcd   (hour_bcd),
  .wday_bcd   (wday_bcd),
  .mday_bcd   (mday_bcd),
  .mon_bcd    (mon_bcd),
  .year_bcd   (year_bcd)
);

// File: tb/bcd_calendar_counter_bench.sv
module bcd_calendar_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [11:0] wr_data = 12'd0;
  logic        sec_strobe;
  logic [7:0]  sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd;
  logic [11:0] year_bcd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bcd_calendar_counter #(.REF_DIV(4)) u_bcd_calendar_counter (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .enable(enable),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_strobe(sec_strobe), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
    .hour_bcd(hour_bcd), .wday_bcd(wday_bcd), .mday_bcd(mday_bcd),
    .mon_bcd(mon_bcd), .year_bcd(year_bcd)
  );

  task automatic chk(input string req, input string what, input logic [11:0] act,
                     input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_field(input logic [2:0] sel, input logic [11:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [11:0] yr, input logic [7:0] mo, input logic [7:0] md,
                          input logic [7:0] wd, input logic [7:0] hr, input logic [7:0] mi,
                          input logic [7:0] se);
    write_field(3'd6, yr);
    write_field(3'd5, {4'h0, mo});
    write_field(3'd4, {4'h0, md});
    write_field(3'd3, {4'h0, wd});
    write_field(3'd2, {4'h0, hr});
    write_field(3'd1, {4'h0, mi});
    write_field(3'd0, {4'h0, se});
  endtask

  task automatic step_second();
    ref_tick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sec_strobe) break;
    end
    ref_tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "sec", {4'h0, sec_bcd}, 12'h000);
    chk("R1", "min", {4'h0, min_bcd}, 12'h000);
    chk("R1", "hour", {4'h0, hour_bcd}, 12'h000);
    chk("R1", "wday", {4'h0, wday_bcd}, 12'h000);
    chk("R1", "mday", {4'h0, mday_bcd}, 12'h001);
    chk("R1", "mon", {4'h0, mon_bcd}, 12'h001);
    chk("R1", "year", year_bcd, 12'h000);
    chk("R1", "strobe", {11'd0, sec_strobe}, 12'h000);
  endtask

  task automatic t_strobe();
    int n;
    @(negedge clk);
    enable = 1'b1; ref_tick = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (sec_strobe) break;
    end
    chk("R2", "first strobe delay", 12'(n), 12'd5);
    @(negedge clk);
    chk("R2", "strobe width", {11'd0, sec_strobe}, 12'h000);
    n = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (sec_strobe) break;
    end
    chk("R2", "strobe period", 12'(n), 12'd4);
    // restart mid-count
    @(negedge clk); @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (sec_strobe) break;
    end
    chk("R2", "restart delay", 12'(n), 12'd5);
    ref_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_readback();
    set_time(12'h987, 8'h07, 8'h15, 8'h03, 8'h12, 8'h45, 8'h37);
    chk("R8", "sec", {4'h0, sec_bcd}, 12'h037);
    chk("R8", "min", {4'h0, min_bcd}, 12'h045);
    chk("R8", "hour", {4'h0, hour_bcd}, 12'h012);
    chk("R8", "wday", {4'h0, wday_bcd}, 12'h003);
    chk("R8", "mday", {4'h0, mday_bcd}, 12'h015);
    chk("R8", "mon", {4'h0, mon_bcd}, 12'h007);
    chk("R8", "year", year_bcd, 12'h987);
  endtask

  task automatic t_carry();
    set_time(12'h050, 8'h05, 8'h10, 8'h02, 8'h10, 8'h59, 8'h58);
    step_second();
    chk("R3", "sec step", {4'h0, sec_bcd}, 12'h059);
    step_second();
    chk("R3", "sec wrap", {4'h0, sec_bcd}, 12'h000);
    chk("R3", "min wrap", {4'h0, min_bcd}, 12'h000);
    chk("R3", "hour carry", {4'h0, hour_bcd}, 12'h011);
    set_time(12'h050, 8'h05, 8'h10, 8'h02, 8'h23, 8'h59, 8'h59);
    step_second();
    chk("R3", "hour wrap", {4'h0, hour_bcd}, 12'h000);
    chk("R4", "wday adv", {4'h0, wday_bcd}, 12'h003);
    chk("R4", "mday adv", {4'h0, mday_bcd}, 12'h011);
  endtask

  task automatic t_wday_wrap();
    set_time(12'h050, 8'h05, 8'h10, 8'h06, 8'h23, 8'h59, 8'h59);
    step_second();
    chk("R4", "wday wrap", {4'h0, wday_bcd}, 12'h000);
  endtask

  task automatic date_case(input string req, input logic [11:0] yr, input logic [7:0] mo,
                           input logic [7:0] md, input logic [11:0] eyr,
                           input logic [7:0] emo, input logic [7:0] emd);
    set_time(yr, mo, md, 8'h01, 8'h23, 8'h59, 8'h59);
    step_second();
    chk(req, "mday", {4'h0, mday_bcd}, {4'h0, emd});
    chk(req, "mon", {4'h0, mon_bcd}, {4'h0, emo});
    chk(req, "year", year_bcd, eyr);
  endtask

  task automatic t_months();
    date_case("R5", 12'h050, 8'h04, 8'h30, 12'h050, 8'h05, 8'h01);
    date_case("R5", 12'h050, 8'h04, 8'h29, 12'h050, 8'h04, 8'h30);
    date_case("R5", 12'h050, 8'h01, 8'h31, 12'h050, 8'h02, 8'h01);
    date_case("R5", 12'h050, 8'h11, 8'h30, 12'h050, 8'h12, 8'h01);
  endtask

  task automatic t_leap();
    date_case("R6", 12'h124, 8'h02, 8'h28, 12'h124, 8'h02, 8'h29);
    date_case("R6", 12'h124, 8'h02, 8'h29, 12'h124, 8'h03, 8'h01);
    date_case("R6", 12'h000, 8'h02, 8'h28, 12'h000, 8'h03, 8'h01);
    date_case("R6", 12'h100, 8'h02, 8'h28, 12'h100, 8'h02, 8'h29);
    date_case("R6", 12'h200, 8'h02, 8'h28, 12'h200, 8'h03, 8'h01);
  endtask

  task automatic t_year();
    date_case("R7", 12'h123, 8'h12, 8'h31, 12'h124, 8'h01, 8'h01);
    date_case("R7", 12'h999, 8'h12, 8'h31, 12'h000, 8'h01, 8'h01);
  endtask

  task automatic t_disabled();
    set_time(12'h050, 8'h05, 8'h10, 8'h02, 8'h08, 8'h20, 8'h30);
    @(negedge clk);
    enable = 1'b0;
    write_field(3'd0, 12'h011);
    write_field(3'd6, 12'h321);
    chk("R9", "sec write ignored", {4'h0, sec_bcd}, 12'h030);
    chk("R9", "year write ignored", year_bcd, 12'h050);
    ref_tick = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9", "no strobe", {11'd0, sec_strobe}, 12'h000);
    chk("R9", "time held", {4'h0, sec_bcd}, 12'h030);
    ref_tick = 1'b0;
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_collision();
    set_time(12'h050, 8'h05, 8'h10, 8'h02, 8'h10, 8'h59, 8'h59);
    ref_tick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sec_strobe) break;
    end
    chk("R10", "strobe reached", {11'd0, sec_strobe}, 12'h001);
    ref_tick = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h042;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10", "sec written", {4'h0, sec_bcd}, 12'h042);
    chk("R10", "no min carry", {4'h0, min_bcd}, 12'h059);
    chk("R10", "no hour carry", {4'h0, hour_bcd}, 12'h010);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_strobe();
    t_readback();
    t_carry();
    t_wday_wrap();
    t_months();
    t_leap();
    t_year();
    t_disabled();
    t_collision();
    finish_run();
  end
endmodule